// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects single-cycle hardware event pulses into a 32-bit cause register and gates them with a 32-bit mask register. It signals software in one of two ways. In legacy mode it drives one level interrupt line. In message mode it drives one request line for each message vector. Software reaches the block through a small register port with a one-cycle read latency. The mask has separate set and clear addresses, so software never needs a read-modify-write sequence. The cause register can be cleared by reading it or by writing ones to it.

In message mode, the transport layer pulses a per-vector acknowledge input once the message has gone out. That pulse can clear the cause bit and mask bit that belong to the vector, and it can also clear a software-chosen group of mask bits. In legacy mode, the same group of mask bits can be set again when software write-clears the cause register. Cause bit 24 is an aggregate: it is set whenever one of the miscellaneous causes (bits 2, 9 and 10) is set, so those causes can share one vector.

Top module: `intr_cause_ctrl`

## Requirements
- R1: After reset the cause, mask and control registers are zero and `irq_out`, `msg_req` and `rd_valid` are low. A cause bit records its event even when its mask bit is zero. A request is only raised for a bit whose cause and mask are both one.
- R2: Each one written to the cause-set register (address 1) sets that cause bit.
- R3: Ones written to mask-set (address 2) set mask bits, and ones written to mask-clear (address 3) clear them. Zero bits leave the mask unchanged.
- R4: Reading address 2 returns the mask. Reading address 1 or 3 returns zero.
- R5: In legacy mode, reading the cause register (address 0) returns its value and clears it. In message mode a read does not clear it.
- R6: In both modes, writing ones to address 0 clears the matching cause bits.
- R7: In the auto-clear register (address 4), only bits 24:20 can be written. When acknowledge v arrives in message mode and bit 20+v is enabled, cause bit 20+v and mask bit 20+v clear.
- R8: In legacy mode, a write-clear to the cause register sets every mask bit that is one both in the written data and in the auto-mask register (address 5).
- R9: In message mode with control bit 1 set, any acknowledge clears every mask bit that is set in the auto-mask register.
- R10: Cause bit 24 becomes set in the same cycle as any of cause bits 2, 9 or 10 becomes set.
- R11: Control bit 0 (address 6) selects message mode. In legacy mode `irq_out` is the OR of cause AND mask, and `msg_req` is zero. In message mode `msg_req[v]` is cause AND mask at bit 20+v, and `irq_out` is low.
- R12: If an event pulse and a clear (by read, write or acknowledge) hit the same cause bit in the same cycle, the bit stays set.
- R13: `rd_valid` and `rd_data` are presented in the cycle after `reg_rd`, holding the value the register had before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | 32 | Event pulses, one per cause bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |
| msg_ack | input | 5 | Per-vector message-sent pulse |
| irq_out | output | 1 | Legacy interrupt line |
| msg_req | output | 5 | Per-vector message request |

## Verification
The bench targets four cases. A cleared bit and a new event in the same cycle: a wrong design would drop the event. An acknowledge that must clear only its own vector's bits: a wrong design would clear other vectors or would still apply the legacy mask re-arm. A cause read in message mode: a wrong design would wipe the pending causes. The aggregate bit 24: a wrong design would leave it stuck set after its miscellaneous source is cleared. Mask checks go through read-back, so a mask-clear with zero bits that still changed the mask, or auto-clear bits written outside 24:20, would show up as a wrong value.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int DW        = 32;
    localparam int AW        = 3;
    localparam int NVEC      = 5;
    localparam int VBASE     = 20;
    localparam int OTHER_BIT = 24;
    localparam logic [DW-1:0] MISC_MASK = 32'h0000_0604;

    typedef enum logic [AW-1:0] {
        A_CAUSE = 3'd0,
        A_CSET  = 3'd1,
        A_MSET  = 3'd2,
        A_MCLR  = 3'd3,
        A_ACEN  = 3'd4,
        A_AMEN  = 3'd5,
        A_CTRL  = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic amask_on;
        logic msg_mode;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0] set;
        logic [DW-1:0] clr;
    } bitop_t;

    function automatic logic [DW-1:0] field_mask(input int lo, input int n);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < DW; i++)
            if (i >= lo && i < lo + n) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq_bit_bank.sv
module irq_bit_bank
    import irq_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  bitop_t       op,
    output logic [W-1:0] bits_q
);
    // Set has priority over clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) bits_q <= '0;
        else     bits_q <= (bits_q & ~op.clr[W-1:0]) | op.set[W-1:0];
    end
endmodule

// File: rtl/irq_req_out.sv
module irq_req_out
    import irq_pkg::*;
#(
    parameter int W   = DW,
    parameter int NV  = NVEC,
    parameter int VB  = VBASE
) (
    input  logic [W-1:0]  cause,
    input  logic [W-1:0]  mask,
    input  logic          msg_mode,
    output logic          irq_out,
    output logic [NV-1:0] msg_req
);
    logic [W-1:0] live;
    assign live    = cause & mask;
    assign irq_out = !msg_mode && (|live);

    for (genvar v = 0; v < NV; v++) begin : g_vec
        assign msg_req[v] = msg_mode && live[VB + v];
    end
endmodule

// File: rtl/intr_cause_ctrl.sv
module intr_cause_ctrl
    import irq_pkg::*;
#(
    parameter int W   = DW,
    parameter int NV  = NVEC,
    parameter int VB  = VBASE,
    parameter int OB  = OTHER_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  hw_evt,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  rd_data,
    output logic          rd_valid,
    input  logic [NV-1:0] msg_ack,
    output logic          irq_out,
    output logic [NV-1:0] msg_req
);
    localparam logic [W-1:0] ACEN_FIELD = field_mask(VB, NV);

    ctrl_t        ctrl_q;
    logic [W-1:0] acen_q, amen_q;
    logic [W-1:0] cause_q, mask_q;
    logic         msg_mode;
    assign msg_mode = ctrl_q.msg_mode;

    // Register decode
    logic wr_cause, wr_cset, wr_mset, wr_mclr, rd_cause;
    assign wr_cause = reg_wr && reg_addr == A_CAUSE;
    assign wr_cset  = reg_wr && reg_addr == A_CSET;
    assign wr_mset  = reg_wr && reg_addr == A_MSET;
    assign wr_mclr  = reg_wr && reg_addr == A_MCLR;
    assign rd_cause = reg_rd && reg_addr == A_CAUSE;

    // Acknowledges spread onto cause bit positions
    logic [W-1:0] ack_bits;
    always_comb begin
        ack_bits = '0;
        for (int v = 0; v < NV; v++)
            ack_bits[VB + v] = msg_mode && msg_ack[v];
    end

    // Cause update
    bitop_t       cause_op;
    logic [W-1:0] raw_set;
    logic         other_evt;
    always_comb begin
        raw_set   = hw_evt | (wr_cset ? reg_wdata : '0);
        other_evt = |(raw_set & MISC_MASK[W-1:0]);
        cause_op.set = '0;
        cause_op.clr = '0;
        cause_op.set[W-1:0] = raw_set;
        cause_op.set[OB]    = raw_set[OB] | other_evt;
        cause_op.clr[W-1:0] = (wr_cause ? reg_wdata : '0)
                            | ((rd_cause && !msg_mode) ? {W{1'b1}} : '0)
                            | (ack_bits & acen_q);
    end

    // Mask update
    bitop_t mask_op;
    always_comb begin
        mask_op.set = '0;
        mask_op.clr = '0;
        mask_op.set[W-1:0] = (wr_mset ? reg_wdata : '0)
                           | ((wr_cause && !msg_mode) ? (reg_wdata & amen_q) : '0);
        mask_op.clr[W-1:0] = (wr_mclr ? reg_wdata : '0)
                           | (ack_bits & acen_q)
                           | ((msg_mode && ctrl_q.amask_on && (|msg_ack)) ? amen_q : '0);
    end

    irq_bit_bank #(.W(W)) u_cause (
        .clk(clk), .rst(rst), .op(cause_op), .bits_q(cause_q)
    );

    irq_bit_bank #(.W(W)) u_mask (
        .clk(clk), .rst(rst), .op(mask_op), .bits_q(mask_q)
    );

    irq_req_out #(.W(W), .NV(NV), .VB(VB)) u_req (
        .cause(cause_q), .mask(mask_q), .msg_mode(msg_mode),
        .irq_out(irq_out), .msg_req(msg_req)
    );

    // Plain configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            acen_q <= '0;
            amen_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_ACEN:  acen_q <= reg_wdata & ACEN_FIELD;
                A_AMEN:  amen_q <= reg_wdata;
                A_CTRL:  ctrl_q <= ctrl_t'(reg_wdata[1:0]);
                default: ;
            endcase
        end
    end

    // Registered read port
    logic [W-1:0] rd_mux;
    always_comb begin
        case (reg_addr)
            A_CAUSE: rd_mux = cause_q;
            A_MSET:  rd_mux = mask_q;
            A_ACEN:  rd_mux = acen_q;
            A_AMEN:  rd_mux = amen_q;
            A_CTRL:  rd_mux = {{(W-2){1'b0}}, ctrl_q};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= reg_rd;
            if (reg_rd) rd_data <= rd_mux;
        end
    end
endmodule

// File: rtl/intr_cause_ctrl_chk.sv
module intr_cause_ctrl_chk
    import irq_pkg::*;
#(
    parameter int W  = DW,
    parameter int NV = NVEC
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  hw_evt,
    input logic [W-1:0]  cause_q,
    input logic [W-1:0]  mask_q,
    input logic          msg_mode,
    input logic          irq_out,
    input logic [NV-1:0] msg_req,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [AW-1:0] reg_addr,
    input logic [W-1:0]  reg_wdata,
    input logic          rd_valid
);
    AST_IRQ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (irq_out || msg_req != '0) |-> ((cause_q & mask_q) != '0)); // R1

    AST_LEGACY_NO_MSG: assert property (@(posedge clk) disable iff (rst)
        !msg_mode |-> (msg_req == '0)); // R11

    AST_MSG_NO_LINE: assert property (@(posedge clk) disable iff (rst)
        msg_mode |-> !irq_out); // R11

    AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (rst)
        (hw_evt != '0) |=> ((cause_q & $past(hw_evt)) == $past(hw_evt))); // R12

    AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_MSET) |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata))); // R3

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> rd_valid); // R13

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !rd_valid); // R13
endmodule

bind intr_cause_ctrl intr_cause_ctrl_chk #(.W(W), .NV(NV)) u_chk (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .cause_q(cause_q), .mask_q(mask_q),
    .msg_mode(msg_mode), .irq_out(irq_out), .msg_req(msg_req),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_valid(rd_valid)
);

// File: tb/sim_intr_cause_ctrl.sv
`timescale 1ns/1ps
module sim_intr_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] hw_evt;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [4:0]  msg_ack;
    logic        irq_out;
    logic [4:0]  msg_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    intr_cause_ctrl u0 (
        .clk(clk), .rst(rst), .hw_evt(hw_evt), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .msg_ack(msg_ack), .irq_out(irq_out), .msg_req(msg_req)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 25;
    localparam step_t TBL [NSTEP] = '{
        '{OP_RD,  3'd0, 32'h0,          32'h0,          8'd1},  // R1 reset cause
        '{OP_WR,  3'd2, 32'h0000_0003,  32'h0,          8'd3},
        '{OP_RD,  3'd2, 32'h0,          32'h0000_0003,  8'd3},  // R3
        '{OP_EV,  3'd0, 32'h0000_0010,  32'h0,          8'd1},
        '{OP_IRQ, 3'd0, 32'h0,          32'h0,          8'd1},  // R1 masked event
        '{OP_RD,  3'd0, 32'h0,          32'h0000_0010,  8'd5},  // R5
        '{OP_RD,  3'd0, 32'h0,          32'h0,          8'd5},  // R5 cleared by read
        '{OP_EV,  3'd0, 32'h0000_0001,  32'h0,          8'd1},
        '{OP_IRQ, 3'd0, 32'h0,          32'h1,          8'd11}, // R11
        '{OP_WR,  3'd0, 32'h0000_0001,  32'h0,          8'd6},
        '{OP_IRQ, 3'd0, 32'h0,          32'h0,          8'd6},  // R6
        '{OP_WR,  3'd1, 32'h0000_0002,  32'h0,          8'd2},
        '{OP_IRQ, 3'd0, 32'h0,          32'h1,          8'd2},  // R2
        '{OP_WR,  3'd3, 32'h0000_0002,  32'h0,          8'd3},
        '{OP_IRQ, 3'd0, 32'h0,          32'h0,          8'd3},  // R3
        '{OP_RD,  3'd2, 32'h0,          32'h0000_0001,  8'd4},  // R4
        '{OP_RD,  3'd3, 32'h0,          32'h0,          8'd4},  // R4 write-only reads zero
        '{OP_EV,  3'd0, 32'h0000_0004,  32'h0,          8'd10},
        '{OP_RD,  3'd0, 32'h0,          32'h0100_0006,  8'd10}, // R10 (bit1 from CSET)
        '{OP_WR,  3'd5, 32'h0000_0100,  32'h0,          8'd8},
        '{OP_WR,  3'd1, 32'h0000_0100,  32'h0,          8'd8},
        '{OP_WR,  3'd0, 32'h0000_0100,  32'h0,          8'd8},
        '{OP_RD,  3'd2, 32'h0,          32'h0000_0101,  8'd8},  // R8
        '{OP_WR,  3'd4, 32'hFFFF_FFFF,  32'h0,          8'd7},
        '{OP_RD,  3'd4, 32'h0,          32'h01F0_0000,  8'd7}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic do_rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = rd_valid ? rd_data : 32'hDEAD_BEEF; // R13 missing valid shows as a wrong value
    endtask

    task automatic do_ev(input logic [31:0] e);
        hw_evt = e;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic do_ack(input logic [4:0] a, input logic [31:0] e);
        msg_ack = a; hw_evt = e;
        @(negedge clk);
        msg_ack = '0; hw_evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; hw_evt = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0; msg_ack = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state of outputs
        check("R1", {29'd0, irq_out, rd_valid, |msg_req}, 32'h0);

        for (int i = 0; i < NSTEP; i++) begin
            case (TBL[i].op)
                OP_WR: do_wr(TBL[i].addr, TBL[i].data);
                OP_EV: do_ev(TBL[i].data);
                OP_RD: begin
                    do_rd(TBL[i].addr, d);
                    check($sformatf("R%0d row %0d", TBL[i].req, i), d, TBL[i].exp);
                end
                default: check($sformatf("R%0d row %0d", TBL[i].req, i), {31'd0, irq_out}, TBL[i].exp);
            endcase
        end

        // Message mode with auto-mask (R11, R9)
        do_wr(3'd6, 32'h3);
        do_wr(3'd2, 32'h0030_0000);
        do_ev(32'h0030_0020);
        check("R11 msg_req", {27'd0, msg_req}, 32'h3);
        check("R11 irq quiet", {31'd0, irq_out}, 32'h0);
        do_ack(5'b00001, 32'h0);
        check("R7 vector0 cleared", {27'd0, msg_req}, 32'h2);
        do_rd(3'd2, d);
        check("R9 auto-mask clear", d, 32'h0020_0001);
        // R12 event beats ack clear on bit 21
        do_ack(5'b00010, 32'h0020_0000);
        check("R12 req masked", {27'd0, msg_req}, 32'h0);
        do_rd(3'd0, d);
        check("R12 event kept", d, 32'h0020_0020);
        do_rd(3'd0, d);
        check("R5 no read-clear in msg mode", d, 32'h0020_0020);
        do_wr(3'd0, 32'h0000_0020);
        do_rd(3'd2, d);
        check("R8 no re-arm in msg mode", d, 32'h0000_0001);
        do_rd(3'd0, d);
        check("R6 write-clear in msg mode", d, 32'h0020_0000);

        // Legacy read-clear racing an event (R12)
        do_wr(3'd6, 32'h0);
        do_rd(3'd0, d);
        check("R5 legacy read", d, 32'h0020_0000);
        hw_evt = 32'h0000_0008; reg_rd = 1'b1; reg_addr = 3'd0;
        @(negedge clk);
        hw_evt = '0; reg_rd = 1'b0;
        check("R13 old value", rd_data, 32'h0);
        do_rd(3'd0, d);
        check("R12 read-clear race", d, 32'h0000_0008);
        do_ev(32'h0000_0200);
        do_rd(3'd0, d);
        check("R10 misc bit 9", d, 32'h0100_0200);
        do_rd(3'd0, d);
        check("R10 aggregate cleared", d, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule